// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address after the translation cache misses on it. A 32-bit virtual address carries a two-bit region field, a 21-bit virtual page number and a 9-bit byte offset, so a page is 512 bytes. Each page-table entry is one 32-bit word. A table holds its entries in page order, so the entry for page n sits at the table base plus 4·n.

A system-space address is resolved with one read, taken from the system table. That table sits in physical memory. A process-space address needs two reads, because the process table sits in system virtual space. The walker first forms the virtual address of the process entry from the process base. It then reads the system entry that maps the page holding that entry, and builds the entry's physical address. Last, it reads the process entry itself. A walk ends in one of two ways: a one-cycle completion strobe with the physical address, or a fault that gives the faulting level and the faulting virtual address.

Memory is reached through a single request/response port. The walker holds the request until the response-valid pulse returns the entry word.

Top module: `ptw_walker`

## Requirements
- R1: A request is taken only when `req_ready` is high, which happens only while idle. `req_ready` drops in the cycle after acceptance. A `req_valid` pulse while a walk is in progress changes neither the result nor `fault_vaddr`.
- R2: A region of 2'b00 marks process space. The first read of such a walk goes to `sys_base + 4*V[29:9]`, where `V = proc_base + 4*vaddr[29:9]` in 32-bit arithmetic. The region bits of V are ignored.
- R3: When the first entry of a process walk is valid, the second read goes to `{entry[20:0], V[8:0]}`.
- R4: A region of 2'b10 marks system space. Such a walk issues exactly one read, at `sys_base + 4*vaddr[29:9]`, using 30-bit physical arithmetic.
- R5: An entry word is valid when bit 31 is set, and bits [20:0] give the frame number. A walk that succeeds raises `done` for exactly one cycle, with `fault` low and `pa_out = {final_entry[20:0], vaddr[8:0]}`. A process walk issues exactly two reads and a system walk exactly one.
- R6: An invalid first entry of a process walk ends the walk after that one read. The walker raises `done` and `fault` with `fault_level` = 1.
- R7: An invalid final entry ends the walk with `done` and `fault` and `fault_level` = 2. The final entry is the second read of a process walk, or the only read of a system walk.
- R8: A region of 2'b01 or 2'b11 raises `done` and `fault` with `fault_level` = 3 in the cycle after acceptance. No memory read is issued.
- R9: Once `mem_req_valid` is raised, it stays high with `mem_req_addr` unchanged until the cycle in which `mem_resp_valid` is high.
- R10: During a fault, `fault_vaddr` equals the virtual address that was accepted for the walk.
- R11: While reset is held, `req_ready` is 1, and `done`, `fault` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request to walk; driven on a cache miss |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| proc_base | input | 32 | System-virtual address of process table entry 0 |
| sys_base | input | 30 | Physical address of system table entry 0 |
| mem_req_valid | output | 1 | Memory read request, held until response |
| mem_req_addr | output | 30 | Physical address of the entry word to read |
| mem_resp_valid | input | 1 | Entry word valid this cycle |
| mem_resp_data | input | 32 | Entry word |
| done | output | 1 | One-cycle end-of-walk strobe |
| pa_out | output | 30 | Translated physical address (with done, fault low) |
| fault | output | 1 | Walk ended in a fault (with done) |
| fault_level | output | 2 | 1 mapping entry, 2 final entry, 3 bad region |
| fault_vaddr | output | 32 | Virtual address of the current or last walk |

## Verification
The properties assume that memory answers only while a read is outstanding, with a single response-valid pulse per read. They also assume the base inputs stay steady from acceptance until completion. The bench memory model follows this: it waits a random zero to three cycles after it sees a request, then drives exactly one response and drops it on the next cycle. The bench changes the bases only between walks. Entry words come from a hash of the read address, so frame numbers vary. The bench sets the valid bit per read position, which reaches both fault levels on demand.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W       = 32;
    localparam int REG_W      = 2;
    localparam int OFS_W      = 9;
    localparam int VPN_W      = VA_W - REG_W - OFS_W;
    localparam int PFN_W      = 21;
    localparam int PA_W       = PFN_W + OFS_W;
    localparam int PTE_W      = 32;
    localparam int PTE_SHIFT  = 2;
    localparam int RSVD_W     = PTE_W - PFN_W - 1;

    localparam logic [REG_W-1:0] RGN_PROC = 2'b00;
    localparam logic [REG_W-1:0] RGN_SYS  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAP_READ,
        ST_LEAF_READ,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_MAP    = 2'd1,
        FLT_LEAF   = 2'd2,
        FLT_REGION = 2'd3
    } fault_level_e;

    typedef struct packed {
        logic [REG_W-1:0] region;
        logic [VPN_W-1:0] vpn;
        logic [OFS_W-1:0] ofs;
    } vaddr_t;

    typedef struct packed {
        logic              valid;
        logic [RSVD_W-1:0] rsvd;
        logic [PFN_W-1:0]  pfn;
    } pte_t;

    function automatic logic [PA_W-1:0] make_pa(input logic [PFN_W-1:0] pfn,
                                                input logic [OFS_W-1:0] ofs);
        return {pfn, ofs};
    endfunction

    function automatic logic region_ok(input logic [REG_W-1:0] r);
        return (r == RGN_PROC) || (r == RGN_SYS);
    endfunction
endpackage

// File: rtl/ptw_pte_index.sv
module ptw_pte_index #(
    parameter int BASE_W = 32,
    parameter int IDX_W  = 21,
    parameter int SHIFT  = 2
) (
    input  logic [BASE_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [BASE_W-1:0] addr
);
    localparam int PAD_W = BASE_W - IDX_W - SHIFT;

    logic [BASE_W-1:0] byte_off;

    assign byte_off = {{PAD_W{1'b0}}, idx, {SHIFT{1'b0}}};
    assign addr     = base + byte_off;
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [REG_W-1:0] region,
    input  logic             resp_valid,
    input  logic             pte_valid,
    output walk_state_e      state
);
    walk_state_e state_d;

    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (region == RGN_PROC)      state_d = ST_MAP_READ;
                    else if (region == RGN_SYS)  state_d = ST_LEAF_READ;
                    else                         state_d = ST_FAULT;
                end
            end
            ST_MAP_READ: begin
                if (resp_valid) state_d = pte_valid ? ST_LEAF_READ : ST_FAULT;
            end
            ST_LEAF_READ: begin
                if (resp_valid) state_d = pte_valid ? ST_DONE : ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    input  logic [VA_W-1:0]  proc_base,
    input  logic [PA_W-1:0]  sys_base,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_resp_valid,
    input  logic [PTE_W-1:0] mem_resp_data,
    output logic             done,
    output logic [PA_W-1:0]  pa_out,
    output logic             fault,
    output logic [1:0]       fault_level,
    output logic [VA_W-1:0]  fault_vaddr
);
    walk_state_e  state;
    vaddr_t       req_va;
    vaddr_t       pte_va;
    pte_t         resp_pte;
    logic [VA_W-1:0]  pte_va_raw;
    logic [VPN_W-1:0] sys_idx;
    logic [PA_W-1:0]  sys_pte_addr;

    vaddr_t           va_q;
    logic [OFS_W-1:0] pte_ofs_q;
    logic [PA_W-1:0]  rd_addr_q;
    logic [PA_W-1:0]  pa_q;
    fault_level_e     flt_q;

    logic unused_bits;

    assign req_va   = vaddr_t'(req_vaddr);
    assign resp_pte = pte_t'(mem_resp_data);
    assign pte_va   = vaddr_t'(pte_va_raw);
    assign unused_bits = ^{pte_va.region, resp_pte.rsvd};

    // Virtual address of the process entry (lives in system space).
    ptw_pte_index #(.BASE_W(VA_W), .IDX_W(VPN_W), .SHIFT(PTE_SHIFT)) u_proc_idx (
        .base (proc_base),
        .idx  (req_va.vpn),
        .addr (pte_va_raw)
    );

    // System table lookup: the request page itself, or the page holding the process entry.
    assign sys_idx = (req_va.region == RGN_SYS) ? req_va.vpn : pte_va.vpn;

    ptw_pte_index #(.BASE_W(PA_W), .IDX_W(VPN_W), .SHIFT(PTE_SHIFT)) u_sys_idx (
        .base (sys_base),
        .idx  (sys_idx),
        .addr (sys_pte_addr)
    );

    ptw_walk_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .region     (req_va.region),
        .resp_valid (mem_resp_valid),
        .pte_valid  (resp_pte.valid),
        .state      (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q      <= '0;
            pte_ofs_q <= '0;
            rd_addr_q <= '0;
            pa_q      <= '0;
            flt_q     <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_va;
                        pte_ofs_q <= pte_va.ofs;
                        rd_addr_q <= sys_pte_addr;
                        pa_q      <= '0;
                        flt_q     <= region_ok(req_va.region) ? FLT_NONE : FLT_REGION;
                    end
                end
                ST_MAP_READ: begin
                    if (mem_resp_valid) begin
                        if (resp_pte.valid) rd_addr_q <= make_pa(resp_pte.pfn, pte_ofs_q);
                        else                flt_q     <= FLT_MAP;
                    end
                end
                ST_LEAF_READ: begin
                    if (mem_resp_valid) begin
                        if (resp_pte.valid) pa_q  <= make_pa(resp_pte.pfn, va_q.ofs);
                        else                flt_q <= FLT_LEAF;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_MAP_READ) || (state == ST_LEAF_READ);
    assign mem_req_addr  = rd_addr_q;
    assign done          = (state == ST_DONE) || (state == ST_FAULT);
    assign fault         = (state == ST_FAULT);
    assign fault_level   = fault ? flt_q : FLT_NONE;
    assign pa_out        = pa_q;
    assign fault_vaddr   = va_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic [29:0] mem_req_addr,
    input logic        mem_resp_valid,
    input logic        done,
    input logic        fault,
    input logic [1:0]  fault_level
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    a_r9_request_held: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_resp_valid |=> mem_req_valid && $stable(mem_req_addr));

    a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_no_read_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req_valid && !req_ready);

    a_r6_fault_has_level: assert property (@(posedge clk) disable iff (rst)
        fault |-> done && (fault_level != 2'd0));

    a_r8_region_fault_direct: assert property (@(posedge clk) disable iff (rst)
        fault && (fault_level == 2'd3) |-> $past(req_ready));
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic [31:0] proc_base = '0;
    logic [29:0] sys_base = '0;
    logic        mem_req_valid;
    logic [29:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        done;
    logic [29:0] pa_out;
    logic        fault;
    logic [1:0]  fault_level;
    logic [31:0] fault_vaddr;

    int checks = 0;
    int errors = 0;
    int nreads = 0;
    logic [29:0] rd_log [0:3];
    bit   vld_by_idx [0:3];

    always #4 clk = ~clk;

    ptw_walker u_ptw_walker (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_word(input logic [29:0] a, input bit v);
        logic [31:0] h;
        h = {2'b00, a} * 32'h9E37_79B1;
        h = h ^ (h >> 13);
        return {v, 10'd0, h[20:0]};
    endfunction

    // Memory model: random latency, one response pulse per read.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_req_valid) begin
                logic [29:0] a0;
                int lat;
                a0  = mem_req_addr;
                lat = $urandom_range(0, 3);
                repeat (lat) @(negedge clk);
                chk(mem_req_valid && mem_req_addr == a0, "R9", "held request addr",
                    {2'b0, mem_req_addr}, {2'b0, a0});
                if (nreads < 4) rd_log[nreads] = a0;
                mem_resp_data  = pte_word(a0, (nreads < 4) ? vld_by_idx[nreads] : 1'b1);
                mem_resp_valid = 1'b1;
                nreads++;
                @(negedge clk);
                mem_resp_valid = 1'b0;
                mem_resp_data  = '0;
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic [31:0] pbr,
                            input logic [29:0] sbr, input bit v0, input bit v1,
                            input bit poke);
        logic [1:0]  rgn;
        logic [31:0] pva;
        logic [29:0] a1, a2, epa;
        logic [31:0] w1, w2;
        int  exp_reads;
        int  exp_lvl;
        @(negedge clk);
        proc_base = pbr; sys_base = sbr;
        vld_by_idx[0] = v0; vld_by_idx[1] = v1;
        nreads = 0; rd_log[0] = '0; rd_log[1] = '0;
        chk(req_ready == 1'b1, "R1", "ready when idle", {31'b0, req_ready}, 32'd1);
        req_vaddr = va; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1", "busy after accept", {31'b0, req_ready}, 32'd0);
        if (poke) begin
            req_vaddr = ~va; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int i = 0; i < 60 && !done; i++) @(negedge clk);

        rgn = va[31:30];
        pva = pbr + {9'd0, va[29:9], 2'b00};
        a1 = '0; a2 = '0; epa = '0; w2 = '0;
        if (rgn == 2'b00) begin
            a1 = sbr + {7'd0, pva[29:9], 2'b00};
            w1 = pte_word(a1, v0);
            if (!w1[31]) begin exp_reads = 1; exp_lvl = 1; end
            else begin
                a2 = {w1[20:0], pva[8:0]};
                w2 = pte_word(a2, v1);
                exp_reads = 2;
                exp_lvl = w2[31] ? 0 : 2;
                epa = {w2[20:0], va[8:0]};
            end
        end else if (rgn == 2'b10) begin
            a1 = sbr + {7'd0, va[29:9], 2'b00};
            w1 = pte_word(a1, v0);
            exp_reads = 1;
            exp_lvl = w1[31] ? 0 : 2;
            epa = {w1[20:0], va[8:0]};
        end else begin
            exp_reads = 0; exp_lvl = 3;
        end

        chk(done == 1'b1, "R5", "done strobe", {31'b0, done}, 32'd1);
        chk(fault == (exp_lvl != 0), "R6", "fault flag", {31'b0, fault}, {31'b0, exp_lvl != 0});
        chk(nreads == exp_reads, (exp_lvl == 3) ? "R8" : "R5", "read count", nreads, exp_reads);
        if (exp_reads >= 1)
            chk(rd_log[0] == a1, (rgn == 2'b10) ? "R4" : "R2", "first read addr",
                {2'b0, rd_log[0]}, {2'b0, a1});
        if (exp_reads == 2)
            chk(rd_log[1] == a2, "R3", "second read addr", {2'b0, rd_log[1]}, {2'b0, a2});
        if (exp_lvl == 0)
            chk(pa_out == epa, "R5", "physical address", {2'b0, pa_out}, {2'b0, epa});
        else begin
            chk(fault_level == exp_lvl[1:0], (exp_lvl == 1) ? "R6" : (exp_lvl == 2) ? "R7" : "R8",
                "fault level", {30'b0, fault_level}, exp_lvl);
            chk(fault_vaddr == va, "R10", "fault vaddr", fault_vaddr, va);
        end
        @(negedge clk);
        chk(done == 1'b0, "R5", "done one cycle", {31'b0, done}, 32'd0);
    endtask

    initial begin
        repeat (600000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5583));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset ready", {31'b0, req_ready}, 32'd1);
        chk(done == 1'b0, "R11", "reset done", {31'b0, done}, 32'd0);
        chk(fault == 1'b0, "R11", "reset fault", {31'b0, fault}, 32'd0);
        chk(mem_req_valid == 1'b0, "R11", "reset mem req", {31'b0, mem_req_valid}, 32'd0);
        rst = 1'b0;

        // Directed corner cases
        run_walk({2'b00, 21'h00_0A5, 9'h1F3}, 32'h8000_4000, 30'h0000_2000, 1, 1, 0); // R2 R3 R5
        run_walk({2'b10, 21'h1F_FFFF, 9'h000}, 32'h8000_0000, 30'h3FFF_FFFC, 1, 1, 0); // R4 wrap
        run_walk({2'b00, 21'h12_3456, 9'h0FF}, 32'hBFFF_FE00, 30'h0100_0000, 0, 1, 0); // R6
        run_walk({2'b00, 21'h00_0001, 9'h001}, 32'h8000_0004, 30'h0000_0400, 1, 0, 0); // R7
        run_walk({2'b10, 21'h00_7777, 9'h1AB}, 32'h8000_0000, 30'h0000_8000, 0, 1, 0); // R7 system
        run_walk({2'b01, 21'h00_0042, 9'h010}, 32'h8000_0000, 30'h0000_1000, 1, 1, 0); // R8
        run_walk({2'b11, 21'h1F_0000, 9'h1FF}, 32'h8000_0000, 30'h0000_1000, 1, 1, 0); // R8
        run_walk({2'b00, 21'h0A_BCDE, 9'h155}, 32'h8001_0000, 30'h0002_0000, 1, 1, 1); // R1 poke
        run_walk({2'b10, 21'h05_5555, 9'h0AA}, 32'h8000_0000, 30'h0003_0000, 1, 1, 1); // R1 poke

        // Constrained random walks
        for (int n = 0; n < 80; n++) begin
            logic [31:0] va;
            logic [31:0] pbr;
            logic [29:0] sbr;
            int sel;
            sel = $urandom_range(0, 9);
            va  = $urandom;
            va[31:30] = (sel < 4) ? 2'b00 : (sel < 8) ? 2'b10 : (sel == 8) ? 2'b01 : 2'b11;
            pbr = {2'b10, 30'($urandom)};
            sbr = 30'($urandom);
            run_walk(va, pbr, sbr, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
                     ($urandom_range(0, 3) == 0) && (va[31:30] inside {2'b00, 2'b10}));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule